// File: doc/BRIEF.md
# Single/Continuous Conversion Controller

This block sequences a converter core between two operating styles. In free-running mode the core converts back to back: every finished conversion is stored and the next one starts in the following cycle. In one-shot mode the core stays powered down until the host asks for a conversion. The core then powers up, converts once, stores the result and powers down again.

The bus interface hands the block a configuration byte and a write strobe, plus a soft-reset pulse for a broadcast reset. The digital filter returns a done pulse together with the result word. The block drives the start pulse and run enable to the filter, the power-down line, the rate and gain fields latched for the conversion in flight, and a read-back byte. That byte carries the live status bit in place of the written start bit. It also holds the result register.

Top module: `conv_mode_ctrl`

## Requirements
- R1: Reset (`rst` or `soft_rst`, synchronous, active high) clears `result` to 0 and sets the configuration to free-running with rate field 3 and gain field 0. `cfg_rd` reads 0x8C: bit 7 status, bits 6:5 zero, bit 4 mode, bits 3:2 rate, bits 1:0 gain. The core is powered down (`pwr_dn`=1, `conv_en`=0) while reset is held, and `conv_start` pulses one cycle after reset is released.
- R2: In free-running mode (bit 4 = 0) the status bit reads 1. Each `done` stores `done_data` into `result` at that edge, `conv_start` pulses in the next cycle and `conv_en` stays 1.
- R3: In one-shot mode, a write with bit 4 = 1 and bit 7 = 1 while powered down sets `conv_en`, clears `pwr_dn` and pulses `conv_start` at the write edge. The status bit then reads 1.
- R4: In one-shot mode, `done` updates `result`, clears the status bit and raises `pwr_dn` at the same edge. No further conversion starts.
- R5: In one-shot mode, a write with bit 7 = 0 starts nothing, and the core stays powered down.
- R6: A write with bit 7 = 1 during a running conversion starts nothing new. The running conversion ends at its `done`.
- R7: A write that changes free-running to one-shot mode lets the conversion in flight finish. The controller then stores the result, clears the status bit and powers down. Bit 7 of that write is ignored.
- R8: `conv_rate` and `conv_gain` take the configuration's rate and gain fields only when a conversion starts. A write during a conversion changes them only at the next start.
- R9: `soft_rst` during a conversion aborts it, zeroes `result`, restores the 0x8C configuration and restarts free-running conversion.
- R10: A `done` pulse while powered down leaves `result` unchanged.
- R11: Writes to bits 6:5 read back as 0. A write that returns to free-running mode while powered down starts a conversion at that write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| soft_rst | input | 1 | Broadcast reset pulse from the bus interface |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte written by the host |
| done | input | 1 | Conversion finished pulse from the filter |
| done_data | input | 16 | Result word that comes with `done` |
| conv_start | output | 1 | One-cycle start pulse to the filter |
| conv_en | output | 1 | Core powered and converting |
| pwr_dn | output | 1 | Core powered down |
| conv_rate | output | 2 | Rate field latched for the current conversion |
| conv_gain | output | 2 | Gain field latched for the current conversion |
| cfg_rd | output | 8 | Read-back byte with the status bit in bit 7 |
| result | output | 16 | Last stored conversion result |

## Verification
The bench sweeps every rate and gain combination in both modes and checks that the latched fields move only at a start. A design that sampled them continuously would change the gain in the middle of a conversion. It aims start requests at a conversion in flight, where a wrong design would restart the core or extend its run. It switches modes mid-conversion, where an eager design would drop the result or never power down. It also fires a done pulse while the core sleeps and a soft reset mid-run. A wrong design would overwrite the held result in the first case, and keep a stale value or a stale configuration in the second.

// File: rtl/conv_ctrl_pkg.sv
package conv_ctrl_pkg;
  localparam int CFG_W    = 8;
  localparam int BIT_STAT = 7;
  localparam int RSVD_HI  = 6;
  localparam int RSVD_LO  = 5;
  localparam int BIT_MODE = 4;
  localparam int RATE_W   = 2;
  localparam int GAIN_W   = 2;
  localparam int RATE_LSB = 2;
  localparam int GAIN_LSB = 0;

  typedef enum logic {ST_OFF = 1'b0, ST_RUN = 1'b1} run_state_t;

  typedef struct packed {
    logic              single;
    logic [RATE_W-1:0] rate;
    logic [GAIN_W-1:0] gain;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{single: 1'b0, rate: '1, gain: '0};
endpackage

// File: rtl/conv_cfg_reg.sv
module conv_cfg_reg
  import conv_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg_q,
  output cfg_t             cfg_nx,
  output logic             start_req
);
  cfg_t wr_val;
  logic unused_rsvd;

  always_comb begin
    wr_val.single = wdata[BIT_MODE];
    wr_val.rate   = wdata[RATE_LSB +: RATE_W];
    wr_val.gain   = wdata[GAIN_LSB +: GAIN_W];
    cfg_nx        = we ? wr_val : cfg_q;
    start_req     = we & wdata[BIT_MODE] & wdata[BIT_STAT];
  end

  assign unused_rsvd = ^wdata[RSVD_HI:RSVD_LO];

  always_ff @(posedge clk) begin
    if (clr) cfg_q <= CFG_DEFAULT;
    else     cfg_q <= cfg_nx;
  end

  a_r1_default_after_clear: assert property (@(posedge clk)
    clr |=> (cfg_q == CFG_DEFAULT));
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
  import conv_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  cfg_t              cfg_nx_i,
  input  logic              start_req_i,
  input  logic              done_i,
  output logic              run_o,
  output logic              conv_start_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [GAIN_W-1:0] gain_o
);
  run_state_t state;
  logic go, again, finish;

  always_comb begin
    go     = (state == ST_OFF) && (!cfg_nx_i.single || start_req_i);
    again  = (state == ST_RUN) && done_i && !cfg_nx_i.single;
    finish = (state == ST_RUN) && done_i && cfg_nx_i.single;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      state        <= ST_OFF;
      conv_start_o <= 1'b0;
      rate_o       <= CFG_DEFAULT.rate;
      gain_o       <= CFG_DEFAULT.gain;
    end else begin
      conv_start_o <= go | again;
      if (go | again) begin
        rate_o <= cfg_nx_i.rate;
        gain_o <= cfg_nx_i.gain;
      end
      if (go)          state <= ST_RUN;
      else if (finish) state <= ST_OFF;
    end
  end

  assign run_o = (state == ST_RUN);

  a_r6_run_holds: assert property (@(posedge clk) disable iff (clr)
    (state == ST_RUN && !done_i) |=> (state == ST_RUN));

  a_r4_single_ends: assert property (@(posedge clk) disable iff (clr)
    (state == ST_RUN && done_i && cfg_nx_i.single) |=> (state == ST_OFF && !conv_start_o));

  a_r8_fields_held: assert property (@(posedge clk) disable iff (clr)
    (state == ST_RUN && !done_i) |=> ($stable(rate_o) && $stable(gain_o)));

  a_r3_start_in_run: assert property (@(posedge clk) disable iff (clr)
    conv_start_o |-> (state == ST_RUN));
endmodule

// File: rtl/conv_result_hold.sv
module conv_result_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  always_ff @(posedge clk) begin
    if (clr)        dout_o <= '0;
    else if (cap_i) dout_o <= din_i;
  end

  a_r9_zero_after_clear: assert property (@(posedge clk)
    clr |=> (dout_o == '0));

  a_r10_hold_without_capture: assert property (@(posedge clk) disable iff (clr)
    !cap_i |=> $stable(dout_o));
endmodule

// File: rtl/conv_mode_ctrl.sv
module conv_mode_ctrl
  import conv_ctrl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              done,
  input  logic [DATA_W-1:0] done_data,
  output logic              conv_start,
  output logic              conv_en,
  output logic              pwr_dn,
  output logic [RATE_W-1:0] conv_rate,
  output logic [GAIN_W-1:0] conv_gain,
  output logic [CFG_W-1:0]  cfg_rd,
  output logic [DATA_W-1:0] result
);
  logic clr, run, start_req, busy;
  cfg_t cfg_q, cfg_nx;

  assign clr = rst | soft_rst;

  conv_cfg_reg u_cfg (
    .clk(clk), .clr(clr), .we(cfg_we), .wdata(cfg_wdata),
    .cfg_q(cfg_q), .cfg_nx(cfg_nx), .start_req(start_req)
  );

  conv_seq_fsm u_fsm (
    .clk(clk), .clr(clr), .cfg_nx_i(cfg_nx), .start_req_i(start_req),
    .done_i(done), .run_o(run), .conv_start_o(conv_start),
    .rate_o(conv_rate), .gain_o(conv_gain)
  );

  conv_result_hold #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .clr(clr), .cap_i(run & done), .din_i(done_data), .dout_o(result)
  );

  always_comb begin
    busy    = !cfg_q.single || run;
    conv_en = run;
    pwr_dn  = !run;
    cfg_rd  = '0;
    cfg_rd[BIT_STAT]                = busy;
    cfg_rd[BIT_MODE]                = cfg_q.single;
    cfg_rd[RATE_LSB +: RATE_W]      = cfg_q.rate;
    cfg_rd[GAIN_LSB +: GAIN_W]      = cfg_q.gain;
  end

  a_r2_free_run_restarts: assert property (@(posedge clk) disable iff (clr)
    (!cfg_q.single && run && done && !cfg_we) |=> (conv_start && conv_en));
endmodule

// File: tb/conv_mode_ctrl_test.sv
`timescale 1ns/1ps
module conv_mode_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1, soft_rst = 1'b0, cfg_we = 1'b0, done = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [15:0] done_data = '0;
  logic        conv_start, conv_en, pwr_dn;
  logic [1:0]  conv_rate, conv_gain;
  logic [7:0]  cfg_rd;
  logic [15:0] result;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  conv_mode_ctrl uut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .done(done), .done_data(done_data), .conv_start(conv_start), .conv_en(conv_en),
    .pwr_dn(pwr_dn), .conv_rate(conv_rate), .conv_gain(conv_gain), .cfg_rd(cfg_rd),
    .result(result)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic fin(input logic [15:0] v);
    done = 1'b1; done_data = v;
    tick();
    done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R1 result", result, 0);
    check("R1 cfg_rd", cfg_rd, 8'h8C);
    check("R1 pwr_dn", pwr_dn, 1);
    check("R1 conv_en", conv_en, 0);
    rst = 1'b0;
    tick();
    check("R1 start after reset", conv_start, 1);
    check("R1 powered", pwr_dn, 0);
    tick();
    check("R1 start single pulse", conv_start, 0);

    for (int i = 0; i < 8; i++) begin
      logic [15:0] d;
      d = (i == 0) ? 16'h7FFF : (i == 1) ? 16'h8000 : (16'(i) * 16'h2461) ^ 16'hA5A5;
      fin(d);
      check("R2 result", result, d);
      check("R2 restart", conv_start, 1);
      check("R2 status", cfg_rd[7], 1);
      tick();
      check("R2 conv_en", conv_en, 1);
      check("R2 pulse ends", conv_start, 0);
    end

    wr(8'h86);
    check("R8 readback", cfg_rd, 8'h86);
    check("R8 rate held", conv_rate, 3);
    check("R8 gain held", conv_gain, 0);
    fin(16'h0102);
    check("R8 rate new", conv_rate, 1);
    check("R8 gain new", conv_gain, 2);

    for (int c = 0; c < 16; c++) begin
      logic [7:0] w;
      w = 8'(c) | ((c % 2 == 1) ? 8'h60 : 8'h00);
      wr(w);
      fin(16'(c) * 16'h0111);
      check("R8 sweep rate", conv_rate, c / 4);
      check("R8 sweep gain", conv_gain, c % 4);
      check("R11 reserved zero", cfg_rd, 8'h80 | 8'(c));
    end

    wr(8'h9C);
    check("R7 readback", cfg_rd, 8'h9C);
    tick(); tick(); tick();
    check("R7 still running", conv_en, 1);
    check("R7 no restart", conv_start, 0);
    fin(16'h4321);
    check("R7 result", result, 16'h4321);
    check("R7 power down", pwr_dn, 1);
    check("R7 status clear", cfg_rd, 8'h1C);
    check("R7 no start", conv_start, 0);
    tick();
    check("R7 stays down", pwr_dn, 1);

    fin(16'hDEAD);
    check("R10 result unchanged", result, 16'h4321);

    wr(8'h1C);
    tick();
    check("R5 stays down", pwr_dn, 1);
    check("R5 no start", conv_start, 0);
    check("R5 readback", cfg_rd, 8'h1C);

    wr(8'h9D);
    check("R3 start", conv_start, 1);
    check("R3 powered", pwr_dn, 0);
    check("R3 status", cfg_rd, 8'h9D);
    check("R3 gain", conv_gain, 1);

    wr(8'h9E);
    check("R6 no restart", conv_start, 0);
    check("R6 gain held", conv_gain, 1);
    check("R6 readback", cfg_rd, 8'h9E);
    fin(16'h0F0F);
    check("R4 result", result, 16'h0F0F);
    check("R4 status clear", cfg_rd, 8'h1E);
    check("R4 power down", pwr_dn, 1);
    tick();
    check("R6 no extra start", conv_start, 0);
    check("R6 stays down", pwr_dn, 1);

    for (int k = 0; k < 4; k++) begin
      logic [15:0] d;
      d = {4'(k), 12'hABC} ^ 16'h8000;
      wr(8'h90 | 8'(k << 2) | 8'(3 - k));
      check("R3 sweep start", conv_start, 1);
      check("R3 sweep rate", conv_rate, k);
      check("R3 sweep gain", conv_gain, 3 - k);
      tick();
      fin(d);
      check("R4 sweep result", result, d);
      check("R4 sweep status", cfg_rd[7], 0);
      check("R4 sweep down", pwr_dn, 1);
    end

    wr(8'h0C);
    check("R11 restart", conv_start, 1);
    check("R11 running", conv_en, 1);
    check("R11 readback", cfg_rd, 8'h8C);

    tick();
    fin(16'h5555);
    check("R2 result before abort", result, 16'h5555);
    wr(8'h07);
    soft_rst = 1'b1;
    tick();
    soft_rst = 1'b0;
    check("R9 result zero", result, 0);
    check("R9 config default", cfg_rd, 8'h8C);
    check("R9 aborted", pwr_dn, 1);
    tick();
    check("R9 restart", conv_start, 1);
    check("R9 rate default", conv_rate, 3);
    check("R9 gain default", conv_gain, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule